// File: doc/BRIEF.md
# Compressed Register-Window Unary and Multiply Unit

This unit executes a small group of short-form integer operations on 32-bit data. Every operation names its operands with 3-bit register specifiers. A specifier selects one register in a window of eight (registers 8 through 15) of a 32-entry register file that sits outside the unit. The first specifier names a register that is both a source and the destination. The unit produces byte and halfword zero- and sign-extension, bitwise inversion, a pass-through, and a multiply that keeps the low 32 bits of the product.

Operations are issued with a valid/ready handshake as an already-decoded 3-bit code plus the two specifiers. The unit drives two combinational read addresses into the register file and gets the read data back in the same cycle. Each result leaves through a registered write-back port that the register file commits at the next clock edge. A unary operation finishes one edge after it is accepted. The multiplier handles `DIGIT_BITS` multiplier bits per cycle, and ready stays low while it runs, so results always leave in the order the operations were accepted. If an operand register is being written back in the cycle it is read, the write-back value is forwarded in its place.

Top module: `cprime_exec_unit`

## Requirements
- R1: The read addresses are `rf_raddr_a = 8 + in_rd` and `rf_raddr_b = 8 + in_rs2`, and each result is written back to `wb_addr = 8 + in_rd` of its own operation.
- R2: Op code 0 writes operand A with bits 31:8 cleared and bits 7:0 kept.
- R3: Op code 1 writes operand A bits 7:0, with bit 7 copied into bits 31:8.
- R4: Op code 2 writes operand A with bits 31:16 cleared and bits 15:0 kept.
- R5: Op code 3 writes operand A bits 15:0, with bit 15 copied into bits 31:16.
- R6: Op code 4 writes the bitwise inverse of operand A.
- R7: Op code 5 writes the low 32 bits of operand A times operand B. The result is the same for signed and unsigned readings of the operands.
- R8: Op codes 6 and 7 are accepted and write operand A back unchanged.
- R9: An operation with a code other than 5 that is accepted at a clock edge raises `wb_valid` for exactly the one cycle after that edge, and `in_ready` stays high.
- R10: A multiply accepted at edge n holds `in_ready` low until edge n+STEPS, where STEPS = 32/DIGIT_BITS (8 by default). Its `wb_valid` pulse follows edge n+STEPS. Exactly one pulse appears for each accepted operation, in acceptance order, and none appears otherwise.
- R11: If an operand register is read in the same cycle that `wb_valid` writes that register, the operand takes `wb_data` instead of the register file data.
- R12: Reset is synchronous and active high. After a reset edge `wb_valid` is 0 and `in_ready` is 1, and an unfinished multiply produces no write-back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | An operation is offered |
| in_ready | output | 1 | The unit can accept an operation this cycle |
| in_op | input | 3 | Decoded operation code (0..7) |
| in_rd | input | 3 | Source/destination register specifier |
| in_rs2 | input | 3 | Second source specifier (multiply only) |
| rf_raddr_a | output | 5 | Register file read address, operand A |
| rf_raddr_b | output | 5 | Register file read address, operand B |
| rf_rdata_a | input | 32 | Read data for operand A (same cycle) |
| rf_rdata_b | input | 32 | Read data for operand B (same cycle) |
| wb_valid | output | 1 | Write-back strobe, one cycle per operation |
| wb_addr | output | 5 | Write-back register address |
| wb_data | output | 32 | Write-back value |

## Verification
Write-back of one operation and the operand read of the next can fall in the same cycle, and the next operation may read the register that is being written. The bench forces this overlap in two ways. It issues dependent operations back to back, and it issues an operation that reads a multiply's destination so that it is accepted in the very cycle the multiply's result appears. The bench register file commits write-backs only at the clock edge, so a missing bypass reads stale data. The error shows up both in the next write-back value, which is compared against an in-order architectural model, and in a final comparison of the whole register window against that model.

// File: rtl/cpx_pkg.sv
package cpx_pkg;

  typedef enum logic [2:0] {
    OP_ZEXT_B = 3'd0,
    OP_SEXT_B = 3'd1,
    OP_ZEXT_H = 3'd2,
    OP_SEXT_H = 3'd3,
    OP_INVERT = 3'd4,
    OP_MULLO  = 3'd5,
    OP_PASS_6 = 3'd6,
    OP_PASS_7 = 3'd7
  } cpx_op_e;

endpackage

// File: rtl/cpx_operand_fetch.sv
module cpx_operand_fetch #(
  parameter int DATA_W   = 32,
  parameter int CREG_W   = 3,
  parameter int RF_AW    = 5,
  parameter int WIN_BASE = 8
) (
  input  logic [CREG_W-1:0] spec_a,
  input  logic [CREG_W-1:0] spec_b,
  input  logic [DATA_W-1:0] rdata_a,
  input  logic [DATA_W-1:0] rdata_b,
  input  logic              byp_valid,
  input  logic [RF_AW-1:0]  byp_addr,
  input  logic [DATA_W-1:0] byp_data,
  output logic [RF_AW-1:0]  raddr_a,
  output logic [RF_AW-1:0]  raddr_b,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b
);

  localparam int NPORT = 2;
  localparam logic [RF_AW-1:0] BASE_L = RF_AW'(WIN_BASE);

  logic [CREG_W-1:0] spec  [NPORT];
  logic [DATA_W-1:0] rdat  [NPORT];
  logic [RF_AW-1:0]  addr  [NPORT];
  logic [DATA_W-1:0] value [NPORT];

  assign spec[0] = spec_a;
  assign spec[1] = spec_b;
  assign rdat[0] = rdata_a;
  assign rdat[1] = rdata_b;

  // one address former and one bypass mux per read port
  for (genvar p = 0; p < NPORT; p++) begin : g_port
    assign addr[p]  = BASE_L + RF_AW'(spec[p]);
    assign value[p] = (byp_valid && (byp_addr == addr[p])) ? byp_data : rdat[p];
  end

  assign raddr_a = addr[0];
  assign raddr_b = addr[1];
  assign opnd_a  = value[0];
  assign opnd_b  = value[1];

endmodule

// File: rtl/cpx_unary_alu.sv
module cpx_unary_alu
  import cpx_pkg::*;
#(
  parameter int DATA_W = 32
) (
  input  cpx_op_e           op,
  input  logic [DATA_W-1:0] opnd,
  output logic [DATA_W-1:0] result
);

  localparam int BYTE_W = 8;
  localparam int HALF_W = 16;

  always_comb begin
    unique case (op)
      OP_ZEXT_B: result = {{(DATA_W-BYTE_W){1'b0}}, opnd[BYTE_W-1:0]};
      OP_SEXT_B: result = {{(DATA_W-BYTE_W){opnd[BYTE_W-1]}}, opnd[BYTE_W-1:0]};
      OP_ZEXT_H: result = {{(DATA_W-HALF_W){1'b0}}, opnd[HALF_W-1:0]};
      OP_SEXT_H: result = {{(DATA_W-HALF_W){opnd[HALF_W-1]}}, opnd[HALF_W-1:0]};
      OP_INVERT: result = opnd ^ {DATA_W{1'b1}};
      default:   result = opnd;
    endcase
  end

endmodule

// File: rtl/cpx_iter_mul.sv
module cpx_iter_mul #(
  parameter int DATA_W     = 32,
  parameter int DIGIT_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [DATA_W-1:0] mcand,
  input  logic [DATA_W-1:0] mplier,
  output logic              busy,
  output logic              fin,
  output logic [DATA_W-1:0] result
);

  localparam int STEPS = DATA_W / DIGIT_BITS;
  localparam int CNT_W = $clog2(STEPS + 1);

  logic [DATA_W-1:0] mc_q, mp_q, acc_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              busy_q;
  logic [DATA_W-1:0] pp [DIGIT_BITS];
  logic [DATA_W-1:0] digit_sum;
  logic [DATA_W-1:0] acc_nxt;

  // partial products of one multiplier digit, truncated to DATA_W
  for (genvar g = 0; g < DIGIT_BITS; g++) begin : g_pp
    assign pp[g] = mp_q[g] ? (mc_q << g) : '0;
  end

  always_comb begin
    digit_sum = '0;
    for (int i = 0; i < DIGIT_BITS; i++) begin
      digit_sum = digit_sum + pp[i];
    end
  end

  assign acc_nxt = acc_q + digit_sum;

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      mc_q   <= '0;
      mp_q   <= '0;
      acc_q  <= '0;
    end else if (busy_q) begin
      mc_q  <= mc_q << DIGIT_BITS;
      mp_q  <= mp_q >> DIGIT_BITS;
      acc_q <= acc_nxt;
      cnt_q <= cnt_q - CNT_W'(1);
      if (cnt_q == CNT_W'(1)) begin
        busy_q <= 1'b0;
      end
    end else if (start) begin
      busy_q <= 1'b1;
      cnt_q  <= CNT_W'(STEPS);
      mc_q   <= mcand;
      mp_q   <= mplier;
      acc_q  <= '0;
    end
  end

  assign busy   = busy_q;
  assign fin    = busy_q && (cnt_q == CNT_W'(1));
  assign result = acc_nxt;

endmodule

// File: rtl/cprime_exec_unit.sv
module cprime_exec_unit
  import cpx_pkg::*;
#(
  parameter int DATA_W     = 32,
  parameter int CREG_W     = 3,
  parameter int RF_AW      = 5,
  parameter int WIN_BASE   = 8,
  parameter int DIGIT_BITS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [2:0]        in_op,
  input  logic [CREG_W-1:0] in_rd,
  input  logic [CREG_W-1:0] in_rs2,
  output logic [RF_AW-1:0]  rf_raddr_a,
  output logic [RF_AW-1:0]  rf_raddr_b,
  input  logic [DATA_W-1:0] rf_rdata_a,
  input  logic [DATA_W-1:0] rf_rdata_b,
  output logic              wb_valid,
  output logic [RF_AW-1:0]  wb_addr,
  output logic [DATA_W-1:0] wb_data
);

  cpx_op_e           op_e;
  logic              accept;
  logic              is_mul;
  logic [DATA_W-1:0] op_a, op_b;
  logic [DATA_W-1:0] alu_res;
  logic              mul_busy, mul_fin;
  logic [DATA_W-1:0] mul_res;
  logic [RF_AW-1:0]  mul_dst_q;

  assign op_e     = cpx_op_e'(in_op);
  assign is_mul   = (op_e == OP_MULLO);
  assign in_ready = ~mul_busy;
  assign accept   = in_valid & in_ready;

  cpx_operand_fetch #(
    .DATA_W  (DATA_W),
    .CREG_W  (CREG_W),
    .RF_AW   (RF_AW),
    .WIN_BASE(WIN_BASE)
  ) u_fetch (
    .spec_a   (in_rd),
    .spec_b   (in_rs2),
    .rdata_a  (rf_rdata_a),
    .rdata_b  (rf_rdata_b),
    .byp_valid(wb_valid),
    .byp_addr (wb_addr),
    .byp_data (wb_data),
    .raddr_a  (rf_raddr_a),
    .raddr_b  (rf_raddr_b),
    .opnd_a   (op_a),
    .opnd_b   (op_b)
  );

  cpx_unary_alu #(
    .DATA_W(DATA_W)
  ) u_alu (
    .op    (op_e),
    .opnd  (op_a),
    .result(alu_res)
  );

  cpx_iter_mul #(
    .DATA_W    (DATA_W),
    .DIGIT_BITS(DIGIT_BITS)
  ) u_mul (
    .clk   (clk),
    .rst   (rst),
    .start (accept && is_mul),
    .mcand (op_a),
    .mplier(op_b),
    .busy  (mul_busy),
    .fin   (mul_fin),
    .result(mul_res)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      mul_dst_q <= '0;
    end else if (accept && is_mul) begin
      mul_dst_q <= rf_raddr_a;
    end
  end

  // registered write-back; unary accept and multiply finish never coincide
  always_ff @(posedge clk) begin
    if (rst) begin
      wb_valid <= 1'b0;
      wb_addr  <= '0;
      wb_data  <= '0;
    end else if (accept && !is_mul) begin
      wb_valid <= 1'b1;
      wb_addr  <= rf_raddr_a;
      wb_data  <= alu_res;
    end else if (mul_fin) begin
      wb_valid <= 1'b1;
      wb_addr  <= mul_dst_q;
      wb_data  <= mul_res;
    end else begin
      wb_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/cprime_exec_unit_chk.sv
module cprime_exec_unit_chk #(
  parameter int DATA_W     = 32,
  parameter int CREG_W     = 3,
  parameter int RF_AW      = 5,
  parameter int WIN_BASE   = 8,
  parameter int DIGIT_BITS = 4
) (
  input logic              clk,
  input logic              rst,
  input logic              in_valid,
  input logic              in_ready,
  input logic [2:0]        in_op,
  input logic [RF_AW-1:0]  rf_raddr_a,
  input logic              wb_valid,
  input logic [RF_AW-1:0]  wb_addr,
  input logic [DATA_W-1:0] wb_data,
  input logic [DATA_W-1:0] op_a
);

  localparam int STEPS  = DATA_W / DIGIT_BITS;
  localparam int LEFT_W = $clog2(STEPS + 1);
  localparam int WIN_N  = 1 << CREG_W;

  logic              acc;
  logic [LEFT_W-1:0] left_q;

  assign acc = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      left_q <= '0;
    end else if (acc && in_op == 3'd5) begin
      left_q <= LEFT_W'(STEPS);
    end else if (left_q != '0) begin
      left_q <= left_q - LEFT_W'(1);
    end
  end

  p_read_window_r1: assert property (@(posedge clk) disable iff (rst)
    in_valid |-> (int'(rf_raddr_a) >= WIN_BASE && int'(rf_raddr_a) < WIN_BASE + WIN_N));

  p_wb_window_r1: assert property (@(posedge clk) disable iff (rst)
    wb_valid |-> (int'(wb_addr) >= WIN_BASE && int'(wb_addr) < WIN_BASE + WIN_N));

  p_zext_b_r2: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 3'd0) |=> (wb_data[DATA_W-1:8] == '0));

  p_sext_b_r3: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 3'd1) |=> (wb_data[DATA_W-1:8] == {(DATA_W-8){wb_data[7]}}));

  p_zext_h_r4: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 3'd2) |=> (wb_data[DATA_W-1:16] == '0));

  p_sext_h_r5: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 3'd3) |=> (wb_data[DATA_W-1:16] == {(DATA_W-16){wb_data[15]}}));

  p_invert_r6: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op == 3'd4) |=> (wb_data == ~$past(op_a)));

  p_pass_r8: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op[2:1] == 2'b11) |=> (wb_data == $past(op_a)));

  p_unary_wb_r9: assert property (@(posedge clk) disable iff (rst)
    (acc && in_op != 3'd5) |=> (wb_valid && in_ready && wb_addr == $past(rf_raddr_a)));

  p_mul_stall_r10: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> !in_ready);

  p_mul_quiet_r10: assert property (@(posedge clk) disable iff (rst)
    (left_q != '0) |-> !wb_valid);

  p_mul_done_r10: assert property (@(posedge clk) disable iff (rst)
    (left_q == LEFT_W'(1)) |=> (wb_valid && in_ready));

  p_reset_r12: assert property (@(posedge clk)
    rst |=> (!wb_valid && in_ready));

endmodule

bind cprime_exec_unit cprime_exec_unit_chk #(
  .DATA_W    (DATA_W),
  .CREG_W    (CREG_W),
  .RF_AW     (RF_AW),
  .WIN_BASE  (WIN_BASE),
  .DIGIT_BITS(DIGIT_BITS)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .in_op     (in_op),
  .rf_raddr_a(rf_raddr_a),
  .wb_valid  (wb_valid),
  .wb_addr   (wb_addr),
  .wb_data   (wb_data),
  .op_a      (op_a)
);

// File: tb/tb_cprime_exec_unit.sv
module tb_cprime_exec_unit;

  localparam int DW    = 32;
  localparam int DIG   = 4;
  localparam int STEPS = DW / DIG;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [2:0]  in_op = '0;
  logic [2:0]  in_rd = '0;
  logic [2:0]  in_rs2 = '0;
  logic [4:0]  rf_raddr_a, rf_raddr_b;
  logic [31:0] rf_rdata_a, rf_rdata_b;
  logic        wb_valid;
  logic [4:0]  wb_addr;
  logic [31:0] wb_data;

  cprime_exec_unit #(.DATA_W(DW), .DIGIT_BITS(DIG)) dut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_op(in_op), .in_rd(in_rd), .in_rs2(in_rs2),
    .rf_raddr_a(rf_raddr_a), .rf_raddr_b(rf_raddr_b),
    .rf_rdata_a(rf_rdata_a), .rf_rdata_b(rf_rdata_b),
    .wb_valid(wb_valid), .wb_addr(wb_addr), .wb_data(wb_data)
  );

  always #5 clk = ~clk;

  typedef struct {
    int          due;
    logic [4:0]  addr;
    logic [31:0] data;
    string       req;
  } exp_t;

  logic [31:0] rf   [32];   // register file seen by the unit, commits at edge
  logic [31:0] arch [32];   // in-order architectural model
  exp_t        q [$];
  int          total = 0;
  int          bad = 0;
  int          cyc = 0;
  int          busy_until = 0;
  bit          done = 1'b0;

  assign rf_rdata_a = rf[rf_raddr_a];
  assign rf_rdata_b = rf[rf_raddr_b];

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%h expected=%h (cycle %0d)", req, what, act, exp, cyc);
    end
  endtask

  function automatic logic [31:0] model_op(input logic [2:0] op, input logic [31:0] a,
                                           input logic [31:0] b);
    case (op)
      3'd0:    return a & 32'h0000_00FF;
      3'd1:    return a[7] ? (a | 32'hFFFF_FF00) : (a & 32'h0000_00FF);
      3'd2:    return a & 32'h0000_FFFF;
      3'd3:    return a[15] ? (a | 32'hFFFF_0000) : (a & 32'h0000_FFFF);
      3'd4:    return ~a;
      3'd5:    return a * b;
      default: return a;
    endcase
  endfunction

  function automatic string op_req(input logic [2:0] op);
    case (op)
      3'd0:    return "R2";
      3'd1:    return "R3";
      3'd2:    return "R4";
      3'd3:    return "R5";
      3'd4:    return "R6";
      3'd5:    return "R7";
      default: return "R8";
    endcase
  endfunction

  // reference model: advances on every edge
  always @(posedge clk) begin
    cyc = cyc + 1;
    if (rst) begin
      q.delete();
      busy_until = 0;
    end else if (in_valid && in_ready) begin
      exp_t e;
      logic [4:0] d;
      d = 5'd8 + {2'b00, in_rd};
      e.data = model_op(in_op, arch[d], arch[5'd8 + {2'b00, in_rs2}]);
      e.addr = d;
      e.req  = op_req(in_op);
      e.due  = (in_op == 3'd5) ? cyc + STEPS : cyc;
      if (in_op == 3'd5) busy_until = cyc + STEPS;
      arch[d] = e.data;
      q.push_back(e);
    end
  end

  always @(posedge clk) begin
    if (wb_valid) rf[wb_addr] <= wb_data;
  end

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!rst && !done) begin
      bit exp_v;
      chk(in_ready == (cyc >= busy_until), "R10", "in_ready",
          {31'd0, in_ready}, {31'd0, cyc >= busy_until});
      exp_v = (q.size() > 0) && (q[0].due == cyc);
      chk(wb_valid == exp_v, "R9 R10", "wb_valid", {31'd0, wb_valid}, {31'd0, exp_v});
      if (exp_v && wb_valid) begin
        chk(wb_addr == q[0].addr, "R1", "wb_addr", {27'd0, wb_addr}, {27'd0, q[0].addr});
        chk(wb_data == q[0].data, q[0].req, "wb_data (R11 bypass path)", wb_data, q[0].data);
      end
      if (exp_v) q.pop_front();
      else if (q.size() > 0 && q[0].due < cyc) q.pop_front();
      if (in_valid) begin
        chk(rf_raddr_a == 5'd8 + {2'b00, in_rd}, "R1", "rf_raddr_a",
            {27'd0, rf_raddr_a}, {27'd0, 5'd8 + {2'b00, in_rd}});
        chk(rf_raddr_b == 5'd8 + {2'b00, in_rs2}, "R1", "rf_raddr_b",
            {27'd0, rf_raddr_b}, {27'd0, 5'd8 + {2'b00, in_rs2}});
      end
    end
  end

  // called at a falling edge; returns at the falling edge after acceptance
  task automatic issue(input logic [2:0] op, input logic [2:0] rd, input logic [2:0] rs);
    in_valid = 1'b1;
    in_op    = op;
    in_rd    = rd;
    in_rs2   = rs;
    forever begin
      bit taken;
      taken = in_ready;
      @(negedge clk);
      if (taken) break;
    end
    in_valid = 1'b0;
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin
      in_op  = 3'($urandom_range(0, 7));
      in_rd  = 3'($urandom_range(0, 7));
      in_rs2 = 3'($urandom_range(0, 7));
      @(negedge clk);
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  endtask

  initial begin
    for (int i = 0; i < 32; i++) begin
      rf[i]   = 32'h9E37_79B9 * (i + 1);
      arch[i] = 32'h9E37_79B9 * (i + 1);
    end
    rf[8]  = 32'h1234_5680; arch[8]  = 32'h1234_5680;
    rf[9]  = 32'hFFFF_7F01; arch[9]  = 32'hFFFF_7F01;
    rf[10] = 32'h0000_8000; arch[10] = 32'h0000_8000;
    rf[11] = 32'h7FFF_FFFF; arch[11] = 32'h7FFF_FFFF;
    rf[12] = 32'h8000_0000; arch[12] = 32'h8000_0000;
    rf[13] = 32'hDEAD_BEEF; arch[13] = 32'hDEAD_BEEF;
    rf[14] = 32'h0000_0000; arch[14] = 32'h0000_0000;
    rf[15] = 32'hFFFF_FFFF; arch[15] = 32'hFFFF_FFFF;

    repeat (3) @(negedge clk);
    chk(wb_valid == 1'b0, "R12", "wb_valid in reset", {31'd0, wb_valid}, 32'd0);
    chk(in_ready == 1'b1, "R12", "in_ready in reset", {31'd0, in_ready}, 32'd1);
    rst = 1'b0;
    idle(2);

    // directed: each unary kind, with dependent back-to-back pairs (R11)
    issue(3'd0, 3'd0, 3'd0);   // R2: x8 -> 0x80
    issue(3'd1, 3'd0, 3'd0);   // R3 + R11: reads the value just written
    issue(3'd2, 3'd1, 3'd0);   // R4
    issue(3'd3, 3'd2, 3'd0);   // R5: 0x8000 -> negative
    issue(3'd3, 3'd1, 3'd0);   // R5: positive halfword
    issue(3'd4, 3'd5, 3'd0);   // R6
    issue(3'd1, 3'd5, 3'd0);   // R3 on inverted value, R11
    idle(1);
    // multiplies: signed corners, zero, self-square (R7, R10)
    issue(3'd5, 3'd3, 3'd4);
    issue(3'd5, 3'd6, 3'd5);
    issue(3'd5, 3'd7, 3'd7);
    // dependent op accepted in the multiply's write-back cycle (R11)
    issue(3'd5, 3'd3, 3'd1);
    issue(3'd4, 3'd3, 3'd0);
    issue(3'd5, 3'd2, 3'd3);   // multiply whose operand B is the prior result
    // reserved codes pass through (R8)
    issue(3'd6, 3'd5, 3'd1);
    issue(3'd7, 3'd3, 3'd2);
    idle(3);

    // random stream with gaps and back-to-back runs
    for (int k = 0; k < 400; k++) begin
      issue(3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)), 3'($urandom_range(0, 7)));
      if ($urandom_range(0, 3) == 0) idle($urandom_range(1, 3));
    end
    idle(STEPS + 4);

    // whole window against the architectural model (R11)
    for (int r = 8; r < 16; r++) begin
      chk(rf[r] == arch[r], "R11", $sformatf("final x%0d", r), rf[r], arch[r]);
    end

    // reset in the middle of a multiply drops it (R12)
    issue(3'd5, 3'd4, 3'd4);
    idle(2);
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    chk(wb_valid == 1'b0, "R12", "wb_valid after reset", {31'd0, wb_valid}, 32'd0);
    chk(in_ready == 1'b1, "R12", "in_ready after reset", {31'd0, in_ready}, 32'd1);
    for (int i = 0; i < STEPS + 2; i++) begin
      @(negedge clk);
      chk(wb_valid == 1'b0, "R12", "no write-back of dropped multiply",
          {31'd0, wb_valid}, 32'd0);
    end
    finish_run();
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      total++;
      bad++;
      $display("FAIL watchdog: run did not finish");
      finish_run();
    end
  end

endmodule